// File: doc/BRIEF.md
# VCO Band Autoselect Controller

This block chooses which of three VCOs, and which of the sixteen sub-bands of that VCO, a frequency synthesizer should run on so that its PLL can lock. A write of the low half of the feedback divider starts a search. The controller applies a candidate band and waits a settle time set by a 2-bit loop-time field. It then reads a 3-bit conversion of the loop tuning voltage. If the reading lies inside a guard window, it accepts the band. Otherwise it steps to the neighbouring band in the direction the reading points. The window is narrower than the plain lock range, which leaves margin for drift over temperature.

Software can skip the search and drive the band directly from manual fields. A search can start from the manually programmed band or from the band the synthesizer is using at that moment. Two flags report the outcome. One is an inactive flag that is low while a search runs. The other is a success flag. When automatic charge-pump selection is on, the controller also reports a charge-pump current code derived from the final band and the last reading.

Top module: `vco_band_select`

## Requirements
- R1: The band is treated as the linear index VCO*16+sub-band, with VCO codes 0, 1 and 2 legal. A search moves only to an adjacent index, so sub-band 15 of one VCO steps up into sub-band 0 of the next VCO, and sub-band 0 steps down into sub-band 15 of the previous VCO. While a search runs, the VCO output never shows code 3.
- R2: When the enable input is 0 and no search runs, the VCO and sub-band outputs equal the manual fields, and a start pulse has no effect: the inactive flag stays 1.
- R3: With the start-mode input at 0, a search begins at the manual VCO and sub-band fields.
- R4: With the start-mode input at 1, a search begins at the band shown on the outputs in the cycle of the start pulse.
- R5: In the cycle after an enabled start pulse, the inactive flag is 0 and the success flag is 0. At the end of the search the inactive flag returns to 1, and the success flag is 1 only if a band was accepted.
- R6: Each candidate band is held for 2^(SETTLE_BASE+LTC) clocks before the reading is judged. A search over k candidates keeps the inactive flag at 0 for exactly k times that count.
- R7: A reading of 2 to 5 accepts the band. A reading of 0 or 1 steps the index down by one, and a reading of 6 or 7 steps it up by one.
- R8: A step below index 0 or above index 47 ends the search with failure, and the outputs keep the last band tried.
- R9: A step to an index already tried in the same search ends it with failure, and the outputs keep the last band tried.
- R10: A start pulse during a running search restarts it from the selected starting band, with a fresh settle time.
- R11: The charge-pump code is sub-band/4 of the accepted band (00 for 0-3, up to 11 for 12-15). It is raised by one, saturating at 11, when the accepting reading is 5. It shows on the output only when auto charge-pump mode is 1, reads 00 otherwise, and reads 00 after a failed search.
- R12: A starting band with VCO code 3 is replaced by VCO code 2 with the same sub-band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse: the divider low byte was written |
| auto_en_i | input | 1 | 1 enables automatic band search |
| start_cur_i | input | 1 | Start point: 0 manual fields, 1 band in use |
| man_vco_i | input | 2 | Manual VCO code |
| man_sub_i | input | 4 | Manual sub-band |
| ltc_i | input | 2 | Loop time constant for the settle wait |
| adc_i | input | 3 | Tuning-voltage conversion code |
| cp_auto_i | input | 1 | 1 enables automatic charge-pump code |
| vco_o | output | 2 | Active VCO code |
| sub_o | output | 4 | Active sub-band |
| idle_o | output | 1 | 1 when no search is running |
| found_o | output | 1 | 1 when the last search accepted a band |
| cp_code_o | output | 2 | Automatic charge-pump code |

## Verification
A bench model of the tuning voltage returns readings as a function of the applied band: above the window for bands below a target, below it for bands above, and a chosen in-window code at the target. Targets placed beyond either end of the band range separate a range-end failure from success. A split model, where the reading flips between two neighbouring bands, separates the revisit failure from a plain range failure. Random targets, start points and start modes are mixed with directed cases at VCO boundaries, every loop-time value, charge-pump saturation and a mid-search restart. These check that both the final band and the busy length match the expected count of candidates.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
   typedef enum logic {
      ST_IDLE   = 1'b0,
      ST_SETTLE = 1'b1
   } vbs_state_e;

   typedef enum logic [1:0] {
      V_LOW  = 2'd0,
      V_OK   = 2'd1,
      V_HIGH = 2'd2
   } vbs_verdict_e;
endpackage

// File: rtl/vbs_settle_timer.sv
module vbs_settle_timer #(
   parameter int BASE  = 10,
   parameter int LTC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [LTC_W-1:0] ltc_i,
   output logic             expired_o
);
   localparam int CNT_W = BASE + (1 << LTC_W);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim_m1;
   logic [LTC_W-1:0] ltc_q;

   always_comb lim_m1 = (CNT_W'(1) << (CNT_W'(BASE) + CNT_W'(ltc_q))) - CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ltc_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
         ltc_q <= ltc_i;
      end else if (run) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign expired_o = run && (cnt_q == lim_m1);
endmodule

// File: rtl/vbs_visit_map.sv
module vbs_visit_map #(
   parameter int N  = 48,
   parameter int IW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          set_en,
   input  logic [IW-1:0] set_idx,
   input  logic [IW-1:0] qry_idx,
   output logic          hit_o
);
   logic [N-1:0] seen_v;

   generate
      for (genvar i = 0; i < N; i++) begin : g_slot
         logic mark_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               mark_q <= 1'b0;
            else if (set_en && set_idx == IW'(i))     mark_q <= 1'b1;
            else if (clear)                           mark_q <= 1'b0;
         end
         assign seen_v[i] = mark_q;
      end
   endgenerate

   always_comb begin
      hit_o = 1'b0;
      for (int i = 0; i < N; i++)
         if (qry_idx == IW'(i)) hit_o = seen_v[i];
   end
endmodule

// File: rtl/vbs_cp_map.sv
module vbs_cp_map #(
   parameter int SUB_W  = 4,
   parameter int ADC_W  = 3,
   parameter int CP_W   = 2,
   parameter int WIN_HI = 5
) (
   input  logic [SUB_W-1:0] sub_i,
   input  logic [ADC_W-1:0] adc_i,
   output logic [CP_W-1:0]  cp_o
);
   logic [CP_W-1:0] base;
   logic            raise;

   assign base  = sub_i[SUB_W-1 -: CP_W];
   assign raise = (adc_i == ADC_W'(WIN_HI)) && (base != {CP_W{1'b1}});
   assign cp_o  = raise ? base + CP_W'(1) : base;
endmodule

// File: rtl/vco_band_select.sv
module vco_band_select
   import vbs_pkg::*;
#(
   parameter int NUM_VCO     = 3,
   parameter int VCO_W       = 2,
   parameter int SUB_W       = 4,
   parameter int ADC_W       = 3,
   parameter int LTC_W       = 2,
   parameter int CP_W        = 2,
   parameter int WIN_LO      = 2,
   parameter int WIN_HI      = 5,
   parameter int SETTLE_BASE = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             auto_en_i,
   input  logic             start_cur_i,
   input  logic [VCO_W-1:0] man_vco_i,
   input  logic [SUB_W-1:0] man_sub_i,
   input  logic [LTC_W-1:0] ltc_i,
   input  logic [ADC_W-1:0] adc_i,
   input  logic             cp_auto_i,
   output logic [VCO_W-1:0] vco_o,
   output logic [SUB_W-1:0] sub_o,
   output logic             idle_o,
   output logic             found_o,
   output logic [CP_W-1:0]  cp_code_o
);
   localparam int              BW    = VCO_W + SUB_W;
   localparam int              NBAND = NUM_VCO * (1 << SUB_W);
   localparam logic [BW-1:0]   LAST  = BW'(NBAND - 1);
   localparam logic [VCO_W-1:0] VTOP = VCO_W'(NUM_VCO - 1);
   localparam logic [ADC_W-1:0] LO_C = ADC_W'(WIN_LO);
   localparam logic [ADC_W-1:0] HI_C = ADC_W'(WIN_HI);

   generate
      if (NUM_VCO < 2 || NUM_VCO > (1 << VCO_W)) begin : g_bad_vco
         $error("NUM_VCO must fit the VCO code width");
      end
      if (CP_W > SUB_W) begin : g_bad_cp
         $error("CP_W cannot exceed SUB_W");
      end
      if (WIN_LO > WIN_HI || WIN_HI >= (1 << ADC_W)) begin : g_bad_win
         $error("acceptance window outside ADC range");
      end
      if (SETTLE_BASE < 1) begin : g_bad_base
         $error("SETTLE_BASE must be at least 1");
      end
   endgenerate

   vbs_state_e     state_q;
   vbs_verdict_e   verdict;
   logic [BW-1:0]  band_q, man_band, out_band, src_band, start_band, next_band;
   logic [VCO_W-1:0] src_vco;
   logic           found_q, go, expired, at_edge, seen_hit, blocked, advance;
   logic [CP_W-1:0] cp_q, cp_calc;

   assign man_band = {man_vco_i, man_sub_i};
   assign out_band = (state_q == ST_IDLE && !auto_en_i) ? man_band : band_q;
   assign go       = start_i && auto_en_i;

   assign src_band   = start_cur_i ? out_band : man_band;
   assign src_vco    = src_band[BW-1 -: VCO_W];
   assign start_band = {(src_vco > VTOP) ? VTOP : src_vco, src_band[SUB_W-1:0]};

   always_comb begin
      if (adc_i < LO_C)      verdict = V_LOW;
      else if (adc_i > HI_C) verdict = V_HIGH;
      else                   verdict = V_OK;
   end

   assign next_band = (verdict == V_LOW) ? band_q - BW'(1) : band_q + BW'(1);
   assign at_edge   = (verdict == V_LOW  && band_q == '0) ||
                      (verdict == V_HIGH && band_q == LAST);
   assign blocked   = at_edge || seen_hit;
   assign advance   = expired && (verdict != V_OK) && !blocked;

   vbs_settle_timer #(.BASE(SETTLE_BASE), .LTC_W(LTC_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (go || advance),
      .run       (state_q == ST_SETTLE),
      .ltc_i     (ltc_i),
      .expired_o (expired)
   );

   vbs_visit_map #(.N(NBAND), .IW(BW)) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (go),
      .set_en  (go || advance),
      .set_idx (go ? start_band : next_band),
      .qry_idx (next_band),
      .hit_o   (seen_hit)
   );

   vbs_cp_map #(.SUB_W(SUB_W), .ADC_W(ADC_W), .CP_W(CP_W), .WIN_HI(WIN_HI)) u_cp (
      .sub_i (band_q[SUB_W-1:0]),
      .adc_i (adc_i),
      .cp_o  (cp_calc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         band_q  <= '0;
         found_q <= 1'b0;
         cp_q    <= '0;
      end else if (go) begin
         state_q <= ST_SETTLE;
         band_q  <= start_band;
         found_q <= 1'b0;
         cp_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (!auto_en_i) band_q <= man_band;
            end
            ST_SETTLE: begin
               if (expired) begin
                  if (verdict == V_OK) begin
                     state_q <= ST_IDLE;
                     found_q <= 1'b1;
                     cp_q    <= cp_calc;
                  end else if (blocked) begin
                     state_q <= ST_IDLE;
                  end else begin
                     band_q  <= next_band;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign vco_o     = out_band[BW-1 -: VCO_W];
   assign sub_o     = out_band[SUB_W-1:0];
   assign idle_o    = (state_q == ST_IDLE);
   assign found_o   = found_q;
   assign cp_code_o = cp_auto_i ? cp_q : '0;
endmodule

// File: rtl/vbs_checker.sv
module vbs_checker #(
   parameter int NUM_VCO = 3,
   parameter int VCO_W   = 2,
   parameter int SUB_W   = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             auto_en_i,
   input logic             start_cur_i,
   input logic [VCO_W-1:0] vco_o,
   input logic [SUB_W-1:0] sub_o,
   input logic             idle_o,
   input logic             found_o
);
   localparam int               BW   = VCO_W + SUB_W;
   localparam logic [VCO_W-1:0] VTOP = VCO_W'(NUM_VCO - 1);

   logic [BW:0] lin;
   assign lin = {1'b0, vco_o, sub_o};

   a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && auto_en_i |=> !idle_o && !found_o);

   a_r5_found_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !idle_o |-> !found_o);

   a_r4_cur_start_keeps_band: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && auto_en_i && start_cur_i && vco_o <= VTOP
      |=> vco_o == $past(vco_o) && sub_o == $past(sub_o));

   a_r1_step_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
      !idle_o && $past(!idle_o) && !$past(start_i)
      |-> lin == $past(lin) || lin == $past(lin) + 1'b1 || lin == $past(lin) - 1'b1);

   a_r1_busy_vco_legal: assert property (@(posedge clk) disable iff (!rst_n)
      !idle_o |-> vco_o <= VTOP);

   a_r8_idle_band_holds: assert property (@(posedge clk) disable iff (!rst_n)
      idle_o && auto_en_i && $past(idle_o && auto_en_i) && !$past(start_i)
      |-> $stable(vco_o) && $stable(sub_o));
endmodule

bind vco_band_select vbs_checker #(
   .NUM_VCO (NUM_VCO),
   .VCO_W   (VCO_W),
   .SUB_W   (SUB_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .auto_en_i   (auto_en_i),
   .start_cur_i (start_cur_i),
   .vco_o       (vco_o),
   .sub_o       (sub_o),
   .idle_o      (idle_o),
   .found_o     (found_o)
);

// File: tb/sim_vco_band_select.sv
module sim_vco_band_select;
   localparam int CLK_PERIOD = 10;
   localparam int SB         = 3;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       start_i = 0, auto_en_i = 0, start_cur_i = 0, cp_auto_i = 0;
   logic [1:0] man_vco_i = 0, ltc_i = 0;
   logic [3:0] man_sub_i = 0;
   logic [2:0] adc_i;
   logic [1:0] vco_o, cp_code_o;
   logic [3:0] sub_o;
   logic       idle_o, found_o;

   int tgt = 0, mode = 0, tcode = 3;
   int n_chk = 0, n_bad = 0, cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int adc_f(int b, int tg, int md, int tc);
      if (md == 1) return (b <= tg) ? 6 + (b & 1) : (b & 1);
      if (b < tg) return 6 + (b & 1);
      if (b > tg) return b & 1;
      return tc;
   endfunction

   assign adc_i = 3'(adc_f(int'({vco_o, sub_o}), tgt, mode, tcode));

   vco_band_select #(.SETTLE_BASE(SB)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .auto_en_i(auto_en_i),
      .start_cur_i(start_cur_i), .man_vco_i(man_vco_i), .man_sub_i(man_sub_i),
      .ltc_i(ltc_i), .adc_i(adc_i), .cp_auto_i(cp_auto_i), .vco_o(vco_o),
      .sub_o(sub_o), .idle_o(idle_o), .found_o(found_o), .cp_code_o(cp_code_o)
   );

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
         finish_run();
      end
   end

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   task automatic model(input int sb, input int tg, input int md, input int tc,
                        output bit ok, output int fin, output int steps);
      bit vis [0:47];
      int b = sb;
      foreach (vis[i]) vis[i] = 0;
      vis[b] = 1; steps = 1; ok = 0; fin = b;
      for (int k = 0; k < 64; k++) begin
         int c = adc_f(b, tg, md, tc);
         int nb;
         fin = b;
         if (c >= 2 && c <= 5) begin ok = 1; break; end
         nb = (c < 2) ? b - 1 : b + 1;
         if (nb < 0 || nb > 47) break;
         if (vis[nb]) break;
         vis[nb] = 1; b = nb; steps++;
      end
   endtask

   task automatic search(int mv, int ms, bit cur, int lt, bit cpa,
                         int tg, int md, int tc, string req);
      int sb, fin, steps, cnt, ecp;
      bit ok;
      @(negedge clk);
      man_vco_i = 2'(mv); man_sub_i = 4'(ms); start_cur_i = cur; ltc_i = 2'(lt);
      cp_auto_i = cpa; tgt = tg; mode = md; tcode = tc; auto_en_i = 1;
      #1;
      sb = cur ? int'({vco_o, sub_o}) : mv * 16 + ms;
      if ((sb >> 4) == 3) sb = 32 + (sb & 15);
      model(sb, tg, md, tc, ok, fin, steps);
      start_i = 1;
      @(negedge clk);
      start_i = 0;
      cnt = 0;
      while (!idle_o && cnt < 20000) begin cnt++; @(negedge clk); end
      ecp = (ok && cpa) ? ((fin & 15) / 4 + ((tc == 5 && (fin & 15) < 12) ? 1 : 0)) : 0;
      chk(found_o == ok, req, "found flag", found_o, ok);
      chk(int'({vco_o, sub_o}) == fin, req, "final band", int'({vco_o, sub_o}), fin);
      chk(cnt == steps * (1 << (SB + lt)), req, "busy cycles", cnt, steps * (1 << (SB + lt)));
      chk(cp_code_o == 2'(ecp), req, "cp code", cp_code_o, ecp);
   endtask

   initial begin
      int seed = 17;
      void'($urandom(seed));
      man_vco_i = 1; man_sub_i = 5;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R5 / R2 reset state
      chk(idle_o == 1, "R5", "reset idle", idle_o, 1);
      chk(found_o == 0, "R5", "reset found", found_o, 0);
      chk(cp_code_o == 0, "R11", "reset cp", cp_code_o, 0);
      chk({vco_o, sub_o} == 6'h15, "R2", "manual band", {vco_o, sub_o}, 6'h15);
      // R2 start ignored when disabled
      start_i = 1; @(negedge clk); start_i = 0;
      repeat (3) begin
         chk(idle_o == 1, "R2", "idle after ignored start", idle_o, 1);
         @(negedge clk);
      end
      man_vco_i = 2; man_sub_i = 9; #1;
      chk({vco_o, sub_o} == 6'h29, "R2", "manual follow", {vco_o, sub_o}, 6'h29);
      // R3 direct hit
      search(1, 3, 0, 0, 1, 19, 0, 3, "R3");
      // R6 each LTC
      for (int l = 0; l < 4; l++) search(0, 8, 0, l, 1, 8, 0, 2, "R6");
      // R1 / R7 carry across VCO boundaries up and down
      search(0, 14, 0, 0, 1, 17, 0, 4, "R1");
      search(2, 1, 0, 1, 1, 29, 0, 3, "R7");
      // R8 range ends
      search(2, 13, 0, 0, 1, 48, 0, 3, "R8");
      search(0, 2, 0, 0, 1, -1, 0, 3, "R8");
      // R9 revisit
      search(1, 4, 0, 0, 1, 20, 1, 3, "R9");
      // R4 from band in use (ends at 21 after R9 case)
      search(0, 0, 1, 0, 1, 21, 0, 2, "R4");
      search(0, 0, 1, 0, 1, 24, 0, 3, "R4");
      // R12 clamp of VCO code 3
      search(3, 7, 0, 0, 1, 39, 0, 3, "R12");
      // R11 charge-pump codes
      search(0, 13, 0, 0, 1, 13, 0, 5, "R11");
      search(1, 6, 0, 0, 1, 22, 0, 5, "R11");
      search(1, 6, 0, 0, 1, 22, 0, 2, "R11");
      search(1, 6, 0, 0, 0, 22, 0, 5, "R11");
      // R10 restart mid-search
      @(negedge clk);
      man_vco_i = 0; man_sub_i = 0; start_cur_i = 0; ltc_i = 0; tgt = 48; mode = 0;
      start_i = 1; @(negedge clk); start_i = 0;
      repeat (20) @(negedge clk);
      chk(idle_o == 0, "R10", "busy before restart", idle_o, 0);
      search(2, 4, 0, 0, 1, 36, 0, 3, "R10");
      // random mix
      for (int t = 0; t < 40; t++) begin
         int mv = $urandom_range(0, 3);
         int tg = $urandom_range(0, 9) == 0 ? ($urandom_range(0, 1) ? 48 : -1)
                                            : int'($urandom_range(0, 47));
         search(mv, $urandom_range(0, 15), 1'($urandom_range(0, 1)),
                $urandom_range(0, 1), 1'($urandom_range(0, 1)), tg,
                $urandom_range(0, 7) == 0 ? 1 : 0, $urandom_range(2, 5), "R7");
      end
      finish_run();
   end
endmodule